// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit holds the program counter of a 32-bit load/store core and chooses its next value on every clock. Each cycle one decoded instruction is presented: its major opcode, function code, the second-register selector, the 16-bit immediate, the 26-bit jump target, and the values read for its two source registers. From these the unit picks one of four successors: the next sequential word, a PC-relative branch target, a target inside the current 256 MB region, or a full register-supplied address.

A REGIMM instruction whose rt selector is neither of the two supported sign tests raises `bad_regimm`. The flag is combinational and holds no state. A build-time switch, `DELAY_SLOT`, adds a one-instruction delay. When it is on, the presented instruction is stored, and its control decision is taken one clock later, against the PC that is current at that time. After reset the stored instruction is a no-op. The unit does not write return addresses.

Top module: `next_pc_unit`

## Requirements
- R1: A synchronous reset loads `pc` with the `RESET_PC` parameter. While reset is held and in the first cycle after it, `bad_regimm` is low when the presented instruction is a no-op (all fields zero).
- R2: Opcode values 8 and above, and opcode 0 with any funct other than 8 or 9, advance `pc` by 4.
- R3: Opcode 0 with funct 8 or funct 9 loads `pc` with `rs_val`.
- R4: Opcodes 2 and 3 keep `pc[31:28]` and load `pc[27:0]` with `{tgt, 2'b00}`.
- R5: Opcode 4 is taken when `rs_val == rt_val`. Opcode 5 is taken when they differ.
- R6: Opcode 6 is taken when `rs_val`, read as signed, is zero or negative. Opcode 7 is taken when it is strictly positive.
- R7: Opcode 1 with `rt_sel` 0 is taken when `rs_val[31]` is 1. Opcode 1 with `rt_sel` 1 is taken when `rs_val[31]` is 0.
- R8: A taken branch sets `pc` to `pc + 4 + {{14{imm[15]}}, imm, 2'b00}`, so negative offsets move backwards. A branch that is not taken sets `pc` to `pc + 4`.
- R9: Opcode 1 with `rt_sel` of 2 or more asserts `bad_regimm` during exactly the cycle in which that instruction is resolved, and `pc` then advances by 4. At all other times the flag is low.
- R10: With `DELAY_SLOT` = 1, the instruction presented in cycle t is resolved in cycle t+1, against the PC held in that cycle, and it determines the PC after the edge that ends cycle t+1. The first cycle after reset resolves a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opc | input | 6 | Major opcode of the presented instruction |
| fn | input | 6 | Function code (used with opcode 0) |
| rt_sel | input | 5 | rt field (selects the REGIMM test) |
| imm | input | 16 | Branch offset in words |
| tgt | input | 26 | Region jump target in words |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| pc | output | 32 | Program counter |
| bad_regimm | output | 1 | Unsupported REGIMM selector in the instruction being resolved |

## Verification
The hardest behaviour to reach from the ports is the delayed build. There, each PC change reflects the instruction presented one cycle earlier, applied to a PC that the instruction before it has already moved. The error flag also has to appear one cycle after the bad opcode was presented. The stimulus chains control transfers back to back: a register jump into a high region, followed at once by a region jump, then branches whose taken and not-taken outcomes alternate. Both builds are driven in parallel from the same stream, and a reference model that holds its own stored decode predicts every PC and flag value.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter logic [31:0] RESET_PC = 32'h0040_0000,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  opc,
  input  logic [5:0]  fn,
  input  logic [4:0]  rt_sel,
  input  logic [15:0] imm,
  input  logic [25:0] tgt,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc,
  output logic        bad_regimm
);

  typedef struct packed {
    logic [5:0]  opc;
    logic [5:0]  fn;
    logic [4:0]  rt_sel;
    logic [15:0] imm;
    logic [25:0] tgt;
    logic [31:0] rs;
    logic [31:0] rt;
  } dec_t;

  dec_t live, act;
  logic [31:0] pc_q, pc_seq, br_dst, rgn_dst, pc_nxt;
  logic take, reg_jmp, rgn_jmp, bad;
  logic rs_neg, rs_zero;

  assign live = '{opc: opc, fn: fn, rt_sel: rt_sel, imm: imm, tgt: tgt, rs: rs_val, rt: rt_val};

  generate
    if (DELAY_SLOT) begin : g_slot
      dec_t held;
      always_ff @(posedge clk)
        if (rst) held <= '0;
        else     held <= live;
      assign act = held;
    end else begin : g_direct
      assign act = live;
    end
  endgenerate

  assign pc_seq  = pc_q + 32'd4;
  assign br_dst  = pc_seq + {{14{act.imm[15]}}, act.imm, 2'b00};
  assign rgn_dst = {pc_q[31:28], act.tgt, 2'b00};
  assign rs_neg  = act.rs[31];
  assign rs_zero = (act.rs == 32'd0);

  always_comb begin
    take    = 1'b0;
    reg_jmp = 1'b0;
    rgn_jmp = 1'b0;
    bad     = 1'b0;
    case (act.opc)
      6'd0: reg_jmp = (act.fn == 6'd8) || (act.fn == 6'd9);
      6'd1: begin
        if (act.rt_sel == 5'd0)      take = rs_neg;
        else if (act.rt_sel == 5'd1) take = !rs_neg;
        else                         bad  = 1'b1;
      end
      6'd2, 6'd3: rgn_jmp = 1'b1;
      6'd4: take = (act.rs == act.rt);
      6'd5: take = (act.rs != act.rt);
      6'd6: take = rs_neg || rs_zero;
      6'd7: take = !rs_neg && !rs_zero;
      default: ;
    endcase
  end

  always_comb begin
    if (reg_jmp)      pc_nxt = act.rs;
    else if (rgn_jmp) pc_nxt = rgn_dst;
    else if (take)    pc_nxt = br_dst;
    else              pc_nxt = pc_seq;
  end

  always_ff @(posedge clk)
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_nxt;

  assign pc         = pc_q;
  assign bad_regimm = bad;

endmodule

// File: rtl/next_pc_unit_chk.sv
module next_pc_unit_chk #(
  parameter logic [31:0] RESET_PC = 32'h0040_0000,
  parameter bit DELAY_SLOT = 1'b0
) (
  input logic        clk,
  input logic        rst,
  input logic [5:0]  opc,
  input logic [5:0]  fn,
  input logic [4:0]  rt_sel,
  input logic [15:0] imm,
  input logic [25:0] tgt,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] pc,
  input logic        bad_regimm
);

  logic [5:0]  v_opc, v_fn;
  logic [4:0]  v_rt_sel;
  logic [15:0] v_imm;
  logic [25:0] v_tgt;
  logic [31:0] v_rs, v_rt;
  logic        rst_q = 1'b0;

  generate
    if (DELAY_SLOT) begin : g_lag
      always_ff @(posedge clk)
        if (rst) begin
          v_opc <= '0; v_fn <= '0; v_rt_sel <= '0; v_imm <= '0;
          v_tgt <= '0; v_rs <= '0; v_rt <= '0;
        end else begin
          v_opc <= opc; v_fn <= fn; v_rt_sel <= rt_sel; v_imm <= imm;
          v_tgt <= tgt; v_rs <= rs_val; v_rt <= rt_val;
        end
    end else begin : g_now
      assign v_opc = opc;
      assign v_fn = fn;
      assign v_rt_sel = rt_sel;
      assign v_imm = imm;
      assign v_tgt = tgt;
      assign v_rs = rs_val;
      assign v_rt = rt_val;
    end
  endgenerate

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) AST_RESET_LOAD: assert (pc == RESET_PC); // R1
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (v_opc >= 6'd8) |=> (pc == $past(pc) + 32'd4)); // R2

  AST_REG_JUMP: assert property (@(posedge clk) disable iff (rst)
    (v_opc == 6'd0 && (v_fn == 6'd8 || v_fn == 6'd9)) |=> (pc == $past(v_rs))); // R3

  AST_REGION_JUMP: assert property (@(posedge clk) disable iff (rst)
    (v_opc == 6'd2 || v_opc == 6'd3) |=>
      (pc[27:0] == {$past(v_tgt), 2'b00} && pc[31:28] == $past(pc[31:28]))); // R4

  AST_EQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (v_opc == 6'd4 && v_rs == v_rt) |=>
      (pc == $past(pc) + 32'd4 + {{14{$past(v_imm[15])}}, $past(v_imm), 2'b00})); // R8

  AST_BAD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (v_opc == 6'd1 && v_rt_sel > 5'd1) |-> bad_regimm); // R9

  AST_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (v_opc != 6'd1) |-> !bad_regimm); // R9

endmodule

bind next_pc_unit next_pc_unit_chk #(.RESET_PC(RESET_PC), .DELAY_SLOT(DELAY_SLOT)) chk (
  .clk(clk), .rst(rst), .opc(opc), .fn(fn), .rt_sel(rt_sel), .imm(imm), .tgt(tgt),
  .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .bad_regimm(bad_regimm)
);

// File: tb/next_pc_unit_test.sv
module next_pc_unit_test;
  localparam logic [31:0] RV = 32'h0040_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opc = '0, fn = '0;
  logic [4:0] rt_sel = '0;
  logic [15:0] imm = '0;
  logic [25:0] tgt = '0;
  logic [31:0] rs_val = '0, rt_val = '0;
  logic [31:0] pc0, pc1;
  logic bad0, bad1;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  next_pc_unit #(.RESET_PC(RV), .DELAY_SLOT(1'b0)) uut (
    .clk(clk), .rst(rst), .opc(opc), .fn(fn), .rt_sel(rt_sel), .imm(imm), .tgt(tgt),
    .rs_val(rs_val), .rt_val(rt_val), .pc(pc0), .bad_regimm(bad0));

  next_pc_unit #(.RESET_PC(RV), .DELAY_SLOT(1'b1)) uut_dly (
    .clk(clk), .rst(rst), .opc(opc), .fn(fn), .rt_sel(rt_sel), .imm(imm), .tgt(tgt),
    .rs_val(rs_val), .rt_val(rt_val), .pc(pc1), .bad_regimm(bad1));

  typedef struct {
    logic [5:0] o, f; logic [4:0] r; logic [15:0] i; logic [25:0] t; logic [31:0] a, b;
  } ins_t;

  typedef struct {
    logic [31:0] p0, p1; logic e0, e1; string tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] m0_pc = RV, m1_pc = RV;
  ins_t saved = '{default: '0};

  function automatic logic [32:0] model(input logic [31:0] p, input ins_t d);
    logic [31:0] nxt = p + 32'd4;
    logic [31:0] off = {{14{d.i[15]}}, d.i, 2'b00};
    logic tk = 1'b0, er = 1'b0;
    logic signed [31:0] s = d.a;
    if (d.o == 6'd0 && (d.f == 6'd8 || d.f == 6'd9)) nxt = d.a;
    else if (d.o == 6'd2 || d.o == 6'd3) nxt = {p[31:28], d.t, 2'b00};
    else begin
      if (d.o == 6'd1) begin
        if (d.r == 5'd0) tk = (s < 0);
        else if (d.r == 5'd1) tk = (s >= 0);
        else er = 1'b1;
      end
      if (d.o == 6'd4) tk = (d.a == d.b);
      if (d.o == 6'd5) tk = (d.a != d.b);
      if (d.o == 6'd6) tk = (s <= 0);
      if (d.o == 6'd7) tk = (s > 0);
      if (tk) nxt = p + 32'd4 + off;
    end
    return {er, nxt};
  endfunction

  task automatic issue(input logic [5:0] o, input logic [5:0] f, input logic [4:0] r,
                       input logic [15:0] i, input logic [25:0] t,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    ins_t d = '{o: o, f: f, r: r, i: i, t: t, a: a, b: b};
    exp_t e;
    logic [32:0] res0, res1;
    opc = o; fn = f; rt_sel = r; imm = i; tgt = t; rs_val = a; rt_val = b;
    res0 = model(m0_pc, d);
    res1 = model(m1_pc, saved);
    e.p0 = m0_pc; e.p1 = m1_pc; e.e0 = res0[32]; e.e1 = res1[32]; e.tag = tag;
    q.push_back(e);
    m0_pc = res0[31:0];
    m1_pc = res1[31:0];
    saved = d;
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(pc0 == e.p0, {e.tag, " pc"}, pc0, e.p0);
        check(bad0 == e.e0, {e.tag, " flag"}, {31'd0, bad0}, {31'd0, e.e0});
        check(pc1 == e.p1, {"R10 ", e.tag, " pc"}, pc1, e.p1);
        check(bad1 == e.e1, {"R10 ", e.tag, " flag"}, {31'd0, bad1}, {31'd0, e.e1});
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(pc0 == RV, "R1 reset pc", pc0, RV);
    check(pc1 == RV, "R1 R10 reset pc", pc1, RV);
    check(!bad0 && !bad1, "R1 reset flag", {30'd0, bad1, bad0}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    issue(6'd8, 6'd0, 5'd0, 16'h0004, 26'd0, 32'd1, 32'd2, "R2 opcode 8");
    issue(6'd0, 6'd0, 5'd0, 16'd0, 26'd0, 32'd0, 32'd0, "R2 funct 0");
    issue(6'd4, 6'd0, 5'd0, 16'h0010, 26'd0, 32'h55, 32'h55, "R5 R8 beq taken");
    issue(6'd4, 6'd0, 5'd0, 16'h0010, 26'd0, 32'h55, 32'h56, "R5 beq not taken");
    issue(6'd5, 6'd0, 5'd0, 16'hFFF8, 26'd0, 32'h1, 32'h2, "R5 R8 bne backward");
    issue(6'd5, 6'd0, 5'd0, 16'hFFF8, 26'd0, 32'h7, 32'h7, "R5 bne not taken");
    issue(6'd6, 6'd0, 5'd0, 16'h0003, 26'd0, 32'd0, 32'd0, "R6 blez zero");
    issue(6'd6, 6'd0, 5'd0, 16'h0003, 26'd0, 32'hFFFF_FFFF, 32'd0, "R6 blez neg");
    issue(6'd6, 6'd0, 5'd0, 16'h0003, 26'd0, 32'd5, 32'd0, "R6 blez pos");
    issue(6'd7, 6'd0, 5'd0, 16'h0005, 26'd0, 32'd0, 32'd0, "R6 bgtz zero");
    issue(6'd7, 6'd0, 5'd0, 16'h0005, 26'd0, 32'h7FFF_FFFF, 32'd0, "R6 bgtz pos");
    issue(6'd1, 6'd0, 5'd0, 16'h0002, 26'd0, 32'h8000_0000, 32'd0, "R7 ltz taken");
    issue(6'd1, 6'd0, 5'd0, 16'h0002, 26'd0, 32'd0, 32'd0, "R7 ltz not taken");
    issue(6'd1, 6'd0, 5'd1, 16'h0002, 26'd0, 32'd0, 32'd0, "R7 gez zero");
    issue(6'd1, 6'd0, 5'd1, 16'h0002, 26'd0, 32'hF000_0000, 32'd0, "R7 gez neg");
    issue(6'd1, 6'd0, 5'd5, 16'h0040, 26'd0, 32'h8000_0000, 32'd0, "R9 bad selector");
    issue(6'd1, 6'd0, 5'd31, 16'h0040, 26'd0, 32'd0, 32'd0, "R9 bad selector 31");
    issue(6'd0, 6'd8, 5'd0, 16'd0, 26'd0, 32'hA000_0100, 32'd0, "R3 register jump");
    issue(6'd2, 6'd0, 5'd0, 16'd0, 26'h123_4567, 32'd0, 32'd0, "R4 region jump");
    issue(6'd0, 6'd9, 5'd0, 16'd0, 26'd0, 32'h0001_0000, 32'd0, "R3 register jump f9");
    issue(6'd3, 6'd0, 5'd0, 16'd0, 26'h3FF_FFFF, 32'd0, 32'd0, "R4 region jump op3");
    issue(6'd63, 6'd8, 5'd3, 16'h8000, 26'h1, 32'h1234, 32'h1234, "R2 opcode 63");
    issue(6'd0, 6'd0, 5'd0, 16'd0, 26'd0, 32'd0, 32'd0, "R2 drain");
    issue(6'd0, 6'd0, 5'd0, 16'd0, 26'd0, 32'd0, 32'd0, "R2 drain 2");
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule